// File: doc/BRIEF.md
# Counting Semaphore Cell

This block is one shared synchronisation cell that holds an unsigned count and serves several requesters through a single request port. Each request carries a view code that selects how the access is interpreted: a raw view that exposes the count without side effects, a tag view that exposes and updates three status flags, a pair of P/V views (one blocking, one polling) where a read takes one unit from the count and a write gives one back, and a pair of empty/full views that only have a meaning for queue cells and do nothing here.

A requester whose blocking take finds the count at zero is told it is blocked and is remembered in a waiter mask. The next give wakes every remembered requester at once with a one-cycle pulse carrying their mask. Woken requesters are expected to retry their take, which may block again if another requester took the unit first. Every request is answered one clock later on the response outputs.

Top module: `sema_cell`

## Requirements
- R1: After reset the count is 0, the T, F and E flags are 0, the waiter mask is 0, and rsp_valid, rsp_blocked and wake_pulse are low.
- R2: A read in view 4 (blocking take) or view 5 (polling take) returns the count as it stood before the access, and lowers the count by one when it was above zero.
- R3: A view-4 read that finds the count at zero answers with rsp_blocked high and data 0, leaves the count at zero, and sets bit req_id of the waiter mask.
- R4: A view-5 read that finds the count at zero answers with data 0 and rsp_blocked low, and leaves both the count and the waiter mask unchanged.
- R5: A write in view 4 or view 5 raises the count by one while it is below the all-ones value of the count width (0xFFFF by default) and holds it there otherwise; its data is ignored.
- R6: A view-4 or view-5 write that finds the waiter mask non-zero raises wake_pulse for one cycle with wake_mask equal to the mask before the write and clears the mask; with an empty mask no pulse occurs.
- R7: A read in view 0 returns the count and leaves it unchanged; a write in view 0 changes nothing.
- R8: A read in view 1 returns T at bit 16, F at bit 1 and E at bit 0, with every other bit 0 (the queue-mode flag at bit 17 reads 0); a write in view 1 loads T, F and E from req_wflags bits 2, 1 and 0 and leaves the count alone.
- R9: Reads in view 2 or view 3 return 0 and writes in those views change nothing.
- R10: Reads in view codes 6 to 15 return all ones and writes in those codes change nothing.
- R11: Each request produces rsp_valid on the following cycle only; a write's response carries data 0 with rsp_blocked low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_view | input | 4 | View code selecting how the access is interpreted |
| req_write | input | 1 | High for a write, low for a read |
| req_id | input | ID_W | Index of the requester |
| req_wflags | input | 3 | Flag values for a tag-view write: {T, F, E} |
| rsp_valid | output | 1 | Response to the previous cycle's request |
| rsp_data | output | 32 | Read data of that response |
| rsp_blocked | output | 1 | The request was parked on an empty count |
| waiter_mask | output | NUM_REQ | Requesters currently parked |
| wake_pulse | output | 1 | One-cycle pulse when parked requesters are released |
| wake_mask | output | NUM_REQ | Requesters released by the pulse |

## Verification
The bench builds the cell with a 4-bit count and four requesters. The narrow count lets twenty gives drive it into its ceiling and fifteen takes drain it again within a short run, so the saturation hold and the decrement down to zero are both reached, while four requesters let the waiter mask collect several distinct bits before one give releases them together. A reference model in the bench predicts every response, flag word and wake pulse from the requirements alone.

// File: rtl/sema_cell_pkg.sv
package sema_cell_pkg;

    localparam int WORD_W = 32;

    // Bit positions of the flag word returned by the tag view.
    localparam int TAG_E_BIT    = 0;
    localparam int TAG_F_BIT    = 1;
    localparam int TAG_T_BIT    = 16;
    localparam int TAG_MODE_BIT = 17;

    typedef enum logic [3:0] {
        VIEW_RAW     = 4'd0,
        VIEW_TAG     = 4'd1,
        VIEW_EF_WAIT = 4'd2,
        VIEW_EF_POLL = 4'd3,
        VIEW_PV_WAIT = 4'd4,
        VIEW_PV_POLL = 4'd5
    } view_e;

    typedef struct packed {
        logic t;
        logic f;
        logic e;
    } tag_t;

endpackage

// File: rtl/sema_counter.sv
module sema_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             give,
    output logic [CNT_W-1:0] count_q
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (give) begin
            if (st_q.cnt != CNT_MAX) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (take) begin
            if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_q = st_q.cnt;

    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (give && count_q == CNT_MAX) |=> (count_q == CNT_MAX));

    a_r2_take_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !give && count_q != '0) |=> (count_q == $past(count_q) - 1'b1));

    a_r3_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !give && count_q == '0) |=> (count_q == '0));

endmodule

// File: rtl/sema_waiters.sv
module sema_waiters #(
    parameter int NUM_REQ = 8,
    parameter int ID_W    = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               park,
    input  logic [ID_W-1:0]    park_id,
    input  logic               release_all,
    output logic [NUM_REQ-1:0] mask_q,
    output logic               pulse_q,
    output logic [NUM_REQ-1:0] woken_q
);

    typedef struct packed {
        logic [NUM_REQ-1:0] mask;
        logic               pulse;
        logic [NUM_REQ-1:0] woken;
    } wait_state_t;

    wait_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        st_d.woken = '0;
        if (release_all) begin
            if (st_q.mask != '0) begin
                st_d.pulse = 1'b1;
                st_d.woken = st_q.mask;
                st_d.mask  = '0;
            end
        end else if (park) begin
            for (int i = 0; i < NUM_REQ; i++) begin
                if (park_id == ID_W'(i)) begin
                    st_d.mask[i] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_q  = st_q.mask;
    assign pulse_q = st_q.pulse;
    assign woken_q = st_q.woken;

    a_r6_mask_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        release_all |=> (mask_q == '0));

    a_r6_pulse_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> (woken_q != '0));

    a_r6_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        (release_all && mask_q != '0) |=> (pulse_q && woken_q == $past(mask_q)));

    a_r3_parked_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (park && !release_all) |=> mask_q[$past(park_id)]);

endmodule

// File: rtl/sema_tag_reg.sv
module sema_tag_reg
    import sema_cell_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [2:0] flags_in,
    output tag_t       tag_q
);

    tag_t tag_d, tag_r;

    always_comb begin
        tag_d = tag_r;
        if (load) begin
            tag_d.t = flags_in[2];
            tag_d.f = flags_in[1];
            tag_d.e = flags_in[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_r <= '0;
        end else begin
            tag_r <= tag_d;
        end
    end

    assign tag_q = tag_r;

    a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(tag_q));

endmodule

// File: rtl/sema_cell.sv
module sema_cell
    import sema_cell_pkg::*;
#(
    parameter  int CNT_W   = 16,
    parameter  int NUM_REQ = 8,
    localparam int ID_W    = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [3:0]         req_view,
    input  logic               req_write,
    input  logic [ID_W-1:0]    req_id,
    input  logic [2:0]         req_wflags,
    output logic               rsp_valid,
    output logic [WORD_W-1:0]  rsp_data,
    output logic               rsp_blocked,
    output logic [NUM_REQ-1:0] waiter_mask,
    output logic               wake_pulse,
    output logic [NUM_REQ-1:0] wake_mask
);

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] data;
        logic              blocked;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [CNT_W-1:0] count_q;
    tag_t             tag_q;
    logic             take, give, park, tag_load;
    logic             is_pv;

    assign is_pv = (req_view == VIEW_PV_WAIT) || (req_view == VIEW_PV_POLL);

    always_comb begin
        take     = req_valid && !req_write && is_pv;
        give     = req_valid &&  req_write && is_pv;
        park     = req_valid && !req_write && (req_view == VIEW_PV_WAIT) && (count_q == '0);
        tag_load = req_valid &&  req_write && (req_view == VIEW_TAG);
    end

    always_comb begin
        rsp_d         = '0;
        rsp_d.valid   = req_valid;
        rsp_d.blocked = park;
        if (req_valid && !req_write) begin
            case (req_view)
                VIEW_RAW: rsp_d.data = WORD_W'(count_q);
                VIEW_TAG: begin
                    rsp_d.data[TAG_T_BIT]    = tag_q.t;
                    rsp_d.data[TAG_F_BIT]    = tag_q.f;
                    rsp_d.data[TAG_E_BIT]    = tag_q.e;
                    rsp_d.data[TAG_MODE_BIT] = 1'b0;
                end
                VIEW_EF_WAIT, VIEW_EF_POLL: rsp_d.data = '0;
                VIEW_PV_WAIT, VIEW_PV_POLL: rsp_d.data = WORD_W'(count_q);
                default: rsp_d.data = '1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    sema_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .give    (give),
        .count_q (count_q)
    );

    sema_waiters #(
        .NUM_REQ (NUM_REQ),
        .ID_W    (ID_W)
    ) u_waiters (
        .clk         (clk),
        .rst_n       (rst_n),
        .park        (park),
        .park_id     (req_id),
        .release_all (give),
        .mask_q      (waiter_mask),
        .pulse_q     (wake_pulse),
        .woken_q     (wake_mask)
    );

    sema_tag_reg u_tag (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tag_load),
        .flags_in (req_wflags),
        .tag_q    (tag_q)
    );

    assign rsp_valid   = rsp_q.valid;
    assign rsp_data    = rsp_q.data;
    assign rsp_blocked = rsp_q.blocked;

    a_r11_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r11_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r3_blocked_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_blocked |-> (rsp_valid && rsp_data == '0));

    a_r11_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_data == '0 && !rsp_blocked));

endmodule

// File: tb/sema_cell_bench.sv
module sema_cell_bench;

    localparam int CNT_W   = 4;
    localparam int NUM_REQ = 4;
    localparam int ID_W    = 2;
    localparam int CMAX    = (1 << CNT_W) - 1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic [3:0]         req_view = '0;
    logic               req_write = 1'b0;
    logic [ID_W-1:0]    req_id = '0;
    logic [2:0]         req_wflags = '0;
    logic               rsp_valid;
    logic [31:0]        rsp_data;
    logic               rsp_blocked;
    logic [NUM_REQ-1:0] waiter_mask;
    logic               wake_pulse;
    logic [NUM_REQ-1:0] wake_mask;

    always #5 clk = ~clk;

    sema_cell #(
        .CNT_W   (CNT_W),
        .NUM_REQ (NUM_REQ)
    ) u_sema_cell (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_view    (req_view),
        .req_write   (req_write),
        .req_id      (req_id),
        .req_wflags  (req_wflags),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .rsp_blocked (rsp_blocked),
        .waiter_mask (waiter_mask),
        .wake_pulse  (wake_pulse),
        .wake_mask   (wake_mask)
    );

    typedef struct {
        logic [31:0]        data;
        logic               blk;
        logic               wp;
        logic [NUM_REQ-1:0] wm;
        logic [NUM_REQ-1:0] wt;
        string              tag;
    } exp_t;

    exp_t sbq[$];
    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Reference model state
    int                 m_cnt = 0;
    bit                 m_t = 0, m_f = 0, m_e = 0;
    logic [NUM_REQ-1:0] m_mask = '0;

    task automatic issue(input int view, input bit wr, input int id,
                         input logic [2:0] fl, input string tag);
        exp_t e;
        e.data = '0; e.blk = 0; e.wp = 0; e.wm = '0; e.tag = tag;
        if (!wr) begin
            case (view)
                0: e.data = 32'(m_cnt);
                1: e.data = (32'(m_t) << 16) | (32'(m_f) << 1) | 32'(m_e);
                2, 3: e.data = '0;
                4, 5: begin
                    e.data = 32'(m_cnt);
                    if (m_cnt > 0) m_cnt--;
                    else if (view == 4) begin
                        e.blk = 1;
                        m_mask[id] = 1'b1;
                    end
                end
                default: e.data = 32'hFFFF_FFFF;
            endcase
        end else begin
            if (view == 1) begin
                m_t = fl[2]; m_f = fl[1]; m_e = fl[0];
            end else if (view == 4 || view == 5) begin
                if (m_cnt < CMAX) m_cnt++;
                if (m_mask != '0) begin
                    e.wp = 1; e.wm = m_mask; m_mask = '0;
                end
            end
        end
        e.wt = m_mask;
        @(negedge clk);
        req_valid  = 1'b1;
        req_view   = 4'(view);
        req_write  = wr;
        req_id     = ID_W'(id);
        req_wflags = fl;
        sbq.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            req_write = 1'b0;
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Monitor: compare each response against the scoreboard head
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            checks++;
            if (sbq.size() == 0) begin
                failures++;
                $display("FAIL R11 actual=unexpected response expected=none");
            end else begin
                exp_t e;
                e = sbq.pop_front();
                if (rsp_data !== e.data || rsp_blocked !== e.blk ||
                    wake_pulse !== e.wp || wake_mask !== e.wm ||
                    waiter_mask !== e.wt) begin
                    failures++;
                    $display("FAIL %s actual=data:%h blk:%0b wp:%0b wm:%b wt:%b expected=data:%h blk:%0b wp:%0b wm:%b wt:%b",
                             e.tag, rsp_data, rsp_blocked, wake_pulse, wake_mask, waiter_mask,
                             e.data, e.blk, e.wp, e.wm, e.wt);
                end
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        check_bit("R1 rsp_valid", rsp_valid, 1'b0);
        check_bit("R1 rsp_blocked", rsp_blocked, 1'b0);
        check_bit("R1 wake_pulse", wake_pulse, 1'b0);
        check_bit("R1 waiter_mask empty", waiter_mask == '0, 1'b1);
        issue(1, 0, 0, 3'b000, "R1 flags zero");
        issue(0, 0, 0, 3'b000, "R1 count zero");

        // R4: polling take at zero
        issue(5, 0, 1, 3'b000, "R4 poll take at zero");
        issue(0, 0, 0, 3'b000, "R4 count still zero");

        // R3: blocking takes at zero park requesters
        issue(4, 0, 2, 3'b000, "R3 park id2");
        issue(4, 0, 1, 3'b000, "R3 park id1");

        // R5/R6: give with data ignored wakes both
        issue(5, 1, 0, 3'b111, "R6 wake on give");
        issue(4, 1, 3, 3'b101, "R6 no pulse on empty mask");
        issue(0, 0, 0, 3'b000, "R5 count after two gives");

        // R2: takes return prior count
        issue(4, 0, 0, 3'b000, "R2 blocking take nonzero");
        issue(5, 0, 0, 3'b000, "R2 polling take nonzero");
        issue(5, 0, 0, 3'b000, "R4 poll take drained");

        // R7: raw view
        issue(4, 1, 0, 3'b000, "R5 give");
        issue(5, 1, 0, 3'b000, "R5 give");
        issue(0, 1, 0, 3'b111, "R7 raw write ignored");
        issue(0, 0, 0, 3'b000, "R7 raw read");
        issue(0, 0, 0, 3'b000, "R7 raw read no side effect");

        // R9: empty/full views
        issue(2, 0, 0, 3'b000, "R9 ef wait read");
        issue(3, 0, 0, 3'b000, "R9 ef poll read");
        issue(2, 1, 0, 3'b111, "R9 ef write");
        issue(3, 1, 0, 3'b111, "R9 ef write");
        issue(0, 0, 0, 3'b000, "R9 count untouched");
        issue(1, 0, 0, 3'b000, "R9 flags untouched");

        // R8: tag view
        issue(1, 1, 0, 3'b111, "R8 tag write all");
        issue(1, 0, 0, 3'b000, "R8 tag read all");
        issue(0, 0, 0, 3'b000, "R8 count untouched");
        issue(1, 1, 0, 3'b010, "R8 tag write F only");
        issue(1, 0, 0, 3'b000, "R8 tag read F only");
        issue(1, 1, 0, 3'b000, "R8 tag clear");
        issue(1, 0, 0, 3'b000, "R8 tag read clear");

        // R10: undefined views
        issue(6, 0, 0, 3'b000, "R10 view 6 read");
        issue(15, 0, 0, 3'b000, "R10 view 15 read");
        issue(9, 1, 0, 3'b111, "R10 view 9 write");
        issue(0, 0, 0, 3'b000, "R10 count untouched");
        issue(1, 0, 0, 3'b000, "R10 flags untouched");

        // R5: saturation
        for (int i = 0; i < 20; i++) issue(4 + (i % 2), 1, 0, 3'b000, "R5 give toward ceiling");
        issue(0, 0, 0, 3'b000, "R5 held at ceiling");
        idle(2);
        for (int i = 0; i < 16; i++) issue(5, 0, 0, 3'b000, "R2 drain");

        // R3/R6: park two, then release together
        issue(4, 0, 0, 3'b000, "R3 park id0");
        issue(4, 0, 3, 3'b000, "R3 park id3");
        issue(4, 0, 3, 3'b000, "R3 park id3 again");
        idle(1);
        issue(4, 1, 2, 3'b000, "R6 release id0 and id3");
        issue(4, 0, 0, 3'b000, "R2 retry after wake");
        issue(4, 0, 3, 3'b000, "R3 retry blocks again");
        issue(5, 1, 1, 3'b000, "R6 release id3");
        idle(4);

        checks++;
        if (sbq.size() != 0) begin
            failures++;
            $display("FAIL R11 actual=%0d pending expected=0", sbq.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule